// File: doc/BRIEF.md
# Pad Pull Programming Sequencer

This block holds the pull setting (none, pull-down, pull-up) of every pad in a bank of general-purpose pins and drives it to the pads. Software cannot address a pin's pull state directly. It first writes a 2-bit code into one shared code register. It then raises the pin's bit in a pull-clock register. On that rising bit the pin copies the shared code into its own state. The pin keeps the state after the clock bit is cleared again. Many pins can be set in a single pass by raising several clock bits together.

The pads need the code to settle before it is clocked in. The block therefore counts bus-clock cycles from the last accepted code write. If a clock bit rises too early, the capture still happens, but a sticky flag is raised so that the programming error can be seen. Pull states are not readable on the bus. Only the code register and the clock registers read back.

Top module: `pad_pull_seq`

## Requirements
- R1: After reset, every pin's pull output is 0 (none), the code register and both clock registers read 0, and `setup_err_o` is 0.
- R2: A write to byte address 0x94 whose bits [1:0] are 0, 1 or 2 (none, pull-down, pull-up) loads that code. A read of 0x94 returns the code in bits [1:0] and zeros above. Write bits [31:2] are ignored.
- R3: A write of code 3 to 0x94 is ignored. It leaves the stored code unchanged and does not restart the setup count.
- R4: Address 0x98 holds the clock bits of pins 0..31 and 0x9C holds those of pins 32..NUM_PINS-1. Both read back the last written value. Bits of 0x9C above the last pin read 0.
- R5: On the edge that writes a clock bit from 0 to 1, that pin loads the stored code. The new value is on `pull_o` from the following cycle.
- R6: A pin keeps its pull state when its clock bit is cleared. It also keeps its state when its bit is written 1 while already 1, even if the code has changed since.
- R7: Pins whose clock bit does not rise keep their state across any write.
- R8: Bit b of the clock register at 0x98+4*k targets pin 32*k+b. Pin p drives `pull_o[2p+1:2p]`.
- R9: A clock bit that rises fewer than SETUP_CYCLES (150) bus cycles after the last accepted code write sets `setup_err_o`. The capture is still applied.
- R10: A rise at SETUP_CYCLES or more cycles after a code write, or a rise with no code write since reset, does not set the flag. Once set, the flag stays at 1 until reset.
- R11: Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pull_o | output | 2*NUM_PINS | Pull code per pin, 2 bits per pin |
| setup_err_o | output | 1 | Sticky flag for a clock bit that rose too early |

## Verification
The assertions assume that `we_i`, `addr_i` and `wdata_i` are stable around each rising edge and that at most one write lands per cycle. The bench meets this by changing the bus only on falling edges. The setup-time properties count cycles from the code-register write edge. The stimulus therefore places clock writes exactly 149 and 150 cycles after a code write to hit both sides of the window. The random phase draws the gap from 0 to 199 cycles, including invalid codes.

// File: rtl/pad_pull_pkg.sv
`timescale 1ns/1ps
package pad_pull_pkg;
  localparam logic [7:0] CODE_ADDR = 8'h94;
  localparam logic [7:0] CLK_BASE  = 8'h98;
  localparam logic [1:0] PULL_NONE = 2'd0;
  localparam logic [1:0] PULL_DOWN = 2'd1;
  localparam logic [1:0] PULL_UP   = 2'd2;

  function automatic logic code_ok(input logic [1:0] c);
    return c != 2'd3;
  endfunction
endpackage

// File: rtl/pull_code_ctl.sv
`timescale 1ns/1ps
module pull_code_ctl import pad_pull_pkg::*; #(
  parameter int SETUP_CYCLES = 150
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       rise_any_i,
  output logic [1:0] code_o,
  output logic       err_o
);
  localparam int CW = $clog2(SETUP_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(SETUP_CYCLES);

  logic [1:0]    code_q;
  logic [CW-1:0] cnt_q;
  logic          err_q;
  logic          load;

  assign load = wr_i && code_ok(wdata_i);

  // cnt_q = edges since last accepted code write, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= PULL_NONE;
      cnt_q  <= CNT_MAX;
      err_q  <= 1'b0;
    end else begin
      if (load) begin
        code_q <= wdata_i;
        cnt_q  <= CW'(1);
      end else if (cnt_q != CNT_MAX) begin
        cnt_q  <= cnt_q + CW'(1);
      end
      if (rise_any_i && cnt_q < CNT_MAX) err_q <= 1'b1;
    end
  end

  assign code_o = code_q;
  assign err_o  = err_q;

  a_r2_code_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i != 2'd3 |=> code_q == $past(wdata_i));
  a_r3_bad_code_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i == 2'd3 |=> $stable(code_q));
  a_r9_early_rise_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_any_i && cnt_q < CNT_MAX |=> err_q);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/pull_clk_bank.sv
`timescale 1ns/1ps
module pull_clk_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [31:0]      bits_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bits_q <= '0;
    else if (wr_i) bits_q <= wdata_i;
  end

  assign rise_o = wr_i ? (wdata_i & ~bits_q) : '0;

  always_comb begin
    bits_o = '0;
    bits_o[WIDTH-1:0] = bits_q;
  end

  a_r4_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(bits_q));
  a_r4_bits_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> bits_q == $past(wdata_i));
endmodule

// File: rtl/pad_pull_cell.sv
`timescale 1ns/1ps
module pad_pull_cell (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_i,
  input  logic [1:0] code_i,
  output logic [1:0] pull_o
);
  logic [1:0] pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pull_q <= 2'd0;
    else if (cap_i) pull_q <= code_i;
  end

  assign pull_o = pull_q;

  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> pull_q == $past(code_i));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(pull_q));
endmodule

// File: rtl/pad_pull_seq.sv
`timescale 1ns/1ps
module pad_pull_seq import pad_pull_pkg::*; #(
  parameter int NUM_PINS     = 54,
  parameter int SETUP_CYCLES = 150
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [7:0]            addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic [2*NUM_PINS-1:0] pull_o,
  output logic                  setup_err_o
);
  localparam int NUM_BANKS = (NUM_PINS + 31) / 32;

  logic                    code_wr;
  logic [1:0]              code;
  logic [NUM_BANKS-1:0]    bank_wr;
  logic [31:0]             bank_rd [NUM_BANKS];
  logic [NUM_BANKS*32-1:0] rise_all;

  assign code_wr = we_i && addr_i == CODE_ADDR;

  pull_code_ctl #(.SETUP_CYCLES(SETUP_CYCLES)) u_code (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (code_wr),
    .wdata_i    (wdata_i[1:0]),
    .rise_any_i (|rise_all),
    .code_o     (code),
    .err_o      (setup_err_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BW = (NUM_PINS - 32*b >= 32) ? 32 : NUM_PINS - 32*b;
    logic [BW-1:0] rise_b;

    assign bank_wr[b] = we_i && addr_i == 8'(CLK_BASE + 8'(4*b));

    pull_clk_bank #(.WIDTH(BW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bank_wr[b]),
      .wdata_i (wdata_i[BW-1:0]),
      .bits_o  (bank_rd[b]),
      .rise_o  (rise_b)
    );

    assign rise_all[32*b +: BW] = rise_b;
    if (BW < 32) begin : g_pad
      assign rise_all[32*b+BW +: 32-BW] = '0;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pad_pull_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (rise_all[p]),
      .code_i (code),
      .pull_o (pull_o[2*p +: 2])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CODE_ADDR) rdata_o = {30'd0, code};
    for (int b = 0; b < NUM_BANKS; b++)
      if (addr_i == 8'(CLK_BASE + 8'(4*b))) rdata_o = bank_rd[b];
  end

  a_r11_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({code_wr, bank_wr}) <= 1);
endmodule

// File: tb/tb_pad_pull_seq.sv
`timescale 1ns/1ps
module tb_pad_pull_seq;
  localparam int NP = 54;
  localparam int SETUP = 150;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [2*NP-1:0] pull;
  logic          err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [1:0]  m_pull [NP];
  logic [1:0]  m_code;
  logic [31:0] m_bank [2];
  logic        m_err;
  int          since;

  pad_pull_seq #(.NUM_PINS(NP), .SETUP_CYCLES(SETUP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pull_o(pull), .setup_err_o(err)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] bank_mask(input int b);
    int w = (NP - 32*b >= 32) ? 32 : NP - 32*b;
    return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [2*NP-1:0] pack_model();
    logic [2*NP-1:0] v;
    for (int p = 0; p < NP; p++) v[2*p +: 2] = m_pull[p];
    return v;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) m_pull[p] = 2'd0;
    m_code = 2'd0; m_bank[0] = '0; m_bank[1] = '0; m_err = 1'b0; since = 1000;
  endtask

  function automatic int inc(input int s);
    return (s >= 1000) ? 1000 : s + 1;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); since = inc(since);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] nv, rise;
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == 8'h94) begin
      if (d[1:0] != 2'd3) begin m_code = d[1:0]; since = 1; end
      else since = inc(since);
    end else if (a == 8'h98 || a == 8'h9C) begin
      int b = (a == 8'h98) ? 0 : 1;
      nv = d & bank_mask(b);
      rise = nv & ~m_bank[b];
      if (rise != 0 && since < SETUP) m_err = 1'b1;
      for (int i = 0; i < 32; i++)
        if (rise[i] && 32*b + i < NP) m_pull[32*b + i] = m_code;
      m_bank[b] = nv;
      since = inc(since);
    end else begin
      since = inc(since);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
    @(negedge clk); since = inc(since);
  endtask

  task automatic chk_state(input string req);
    chk({req, " pull state"}, 128'(pull), 128'(pack_model()));
    chk({req, " setup flag"}, 128'(err), 128'(m_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED));
    model_reset();
    do_reset();

    // R1 reset state
    chk("R1 pull", 128'(pull), 128'd0);
    chk("R1 flag", 128'(err), 128'd0);
    rd(8'h94, d); chk("R1 code reg", 128'(d), 128'd0);
    rd(8'h98, d); chk("R1 clk bank0", 128'(d), 128'd0);
    rd(8'h9C, d); chk("R1 clk bank1", 128'(d), 128'd0);

    // R2 code load and readback
    do_write(8'h94, 32'd2); rd(8'h94, d); chk("R2 code 2", 128'(d), 128'd2);
    do_write(8'h94, 32'hFFFF_FFF1); rd(8'h94, d); chk("R2 upper ignored", 128'(d), 128'd1);
    // R3 invalid code ignored
    do_write(8'h94, 32'd3); rd(8'h94, d); chk("R3 code 3 ignored", 128'(d), 128'd1);

    // R5 R8 R10 capture after full settle
    idle(150);
    do_write(8'h98, 32'h20);
    chk("R5 pin5 pulldown", 128'(pull[11:10]), 128'd1);
    chk("R10 no flag after settle", 128'(err), 128'd0);
    rd(8'h98, d); chk("R4 bank0 readback", 128'(d), 128'h20);

    // R6 no recapture on held bit, R5 new pin
    do_write(8'h94, 32'd2); idle(150);
    do_write(8'h98, 32'h60);
    chk("R6 pin5 held", 128'(pull[11:10]), 128'd1);
    chk("R5 pin6 pullup", 128'(pull[13:12]), 128'd2);
    do_write(8'h98, 32'h0);
    chk("R6 hold after clear", 128'(pull[13:10]), 128'h9);
    chk_state("R6");

    // R4 R8 second bank
    do_write(8'h9C, 32'hFFFF_FFFF);
    rd(8'h9C, d); chk("R4 bank1 unused bits zero", 128'(d), 128'h3F_FFFF);
    chk("R8 pin32 pullup", 128'(pull[65:64]), 128'd2);
    chk("R7 pin31 untouched", 128'(pull[63:62]), 128'd0);
    chk_state("R8");

    // R3 invalid code does not restart the setup count
    do_write(8'h94, 32'd1); idle(148);
    do_write(8'h94, 32'd3);
    do_write(8'h98, 32'h80);
    chk("R3 no timer restart", 128'(err), 128'd0);
    chk("R5 pin7 pulldown", 128'(pull[15:14]), 128'd1);

    // R11 unmapped address
    do_write(8'hA0, 32'hFFFF_FFFF);
    rd(8'hA0, d); chk("R11 unmapped read", 128'(d), 128'd0);
    rd(8'h94, d); chk("R11 code intact", 128'(d), 128'd1);
    rd(8'h98, d); chk("R11 bank0 intact", 128'(d), 128'h80);
    chk_state("R11");

    // R10 no rise means no flag even right after a code write
    do_write(8'h94, 32'd0);
    do_write(8'h98, 32'h80);
    do_write(8'h98, 32'h0);
    chk("R10 no rise no flag", 128'(err), 128'd0);
    chk("R6 pin7 kept", 128'(pull[15:14]), 128'd1);

    // R9 rise at 149 cycles flags, capture still applied
    do_write(8'h94, 32'd2); idle(148);
    do_write(8'h98, 32'h180);
    chk("R9 early rise flag", 128'(err), 128'd1);
    chk("R9 capture applied", 128'(pull[17:14]), 128'hA);
    idle(5);
    do_write(8'h94, 32'd1); idle(200); do_write(8'h98, 32'h200);
    chk("R10 flag sticky", 128'(err), 128'd1);
    chk_state("R9");

    // R1 R10 reset clears everything
    do_reset();
    chk("R10 reset clears flag", 128'(err), 128'd0);
    chk("R1 pulls cleared", 128'(pull), 128'd0);

    // random phase
    for (int it = 0; it < 40; it++) begin
      logic [31:0] r = $urandom;
      do_write(8'h94, (r & ~32'd3) | 32'($urandom % 4));
      idle($urandom % 200);
      if ($urandom % 2 == 0) do_write(8'h98, $urandom);
      else                   do_write(8'h9C, $urandom);
      chk_state("R5 R7 R9 random");
      rd(8'h94, d); chk("R2 random code", 128'(d), 128'(m_code));
      rd(8'h98, d); chk("R4 random bank0", 128'(d), 128'(m_bank[0]));
      rd(8'h9C, d); chk("R4 random bank1", 128'(d), 128'(m_bank[1]));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule